// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster input clock. The divide ratio is a fixed-point number with four fraction bits. When the ratio is not a whole number, the length of each output period is either the integer part or the integer part plus one input cycle. A phase accumulator picks between the two, so the average period matches the programmed ratio.

Inside each period, the output goes high and low at positions set in half input-cycle units. This gives half-cycle control of the duty cycle. A single input bit inverts the output. A one-cycle tick marks the first input cycle of every output period, so downstream timing counters can step in lockstep with the pixel clock.

A new ratio or new edge positions are taken only at the start of a period. The period in progress always completes with its old settings, which keeps the output free of glitches when the configuration changes.

Top module: `fclk_divider`

## Requirements
- R1: While reset is held, tick_o is 0 and pix_clk_o is 0 in both halves of every input cycle (with invert_i at 0).
- R2: A divide value of N*16 (integer ratio N, low 4 bits zero) gives output periods of exactly N input cycles, and tick_o is high once per period.
- R3: For a divide value with a nonzero fraction F (low 4 bits) and integer part N (bits 11:4), every period lasts N or N+1 cycles, and any 16 consecutive periods total 16*N+F cycles. For F=8, the two lengths alternate.
- R4: A divide value below 16 behaves exactly like 16.
- R5: With a divide value of 16, rise position 0 and fall position 1, pix_clk_o follows the input clock: high in the first half of each input cycle and low in the second half.
- R6: edge_cfg_i bits 8:0 hold the rise position and bits 24:16 hold the fall position, both in half-cycle units. Half slot h is 2*k for the first half of cycle k of the period and 2*k+1 for its second half. When rise <= fall, the output is high in the slots with rise <= h < fall.
- R7: When rise > fall, the output is high in the slots with h >= rise or h < fall (the high phase wraps across the period start).
- R8: invert_i at 1 inverts pix_clk_o in every half cycle.
- R9: A change of divide value or edge positions takes effect only at the next period start. The period in progress keeps its old length.
- R10: tick_o is high for exactly the first input cycle of each output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_cfg_i | input | 12 | Divide ratio, 8 integer bits over 4 fraction bits |
| edge_cfg_i | input | 32 | Fall position in bits 24:16 and rise position in bits 8:0, half-cycle units |
| invert_i | input | 1 | Invert the output clock |
| pix_clk_o | output | 1 | Divided pixel clock |
| tick_o | output | 1 | High in the first input cycle of each output period |

## Verification
The bench measures every period it observes: its length in cycles, how many half slots are high, and the level in the first half slot. It drives pass-through settings, whole ratios of 3 and 4, the fractions 2.5 and 2.25, a below-minimum ratio, and normal, wrapped and inverted edge windows. Whole ratios catch off-by-one errors in the length. The 16-period sums catch a wrong accumulator carry. Half-slot counts and first-slot levels separate a correct window from one that is shifted, not wrapped, or inverted. A ratio change made mid-period shows whether the new value is taken early.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
    parameter int DEF_DIV_W    = 12;
    parameter int DEF_FRAC_W   = 4;
    parameter int DEF_EDGE_W   = 9;
    parameter int DEF_CFG_W    = 32;
    parameter int DEF_FALL_LSB = 16;
    parameter int DEF_RISE_LSB = 0;
endpackage

// File: rtl/fclk_period_calc.sv
module fclk_period_calc #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    localparam int INT_W = DIV_W - FRAC_W,
    localparam int LEN_W = INT_W + 1
) (
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] acc_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [FRAC_W-1:0] acc_o
);
    localparam logic [DIV_W-1:0] UNITY = DIV_W'(1) << FRAC_W;

    logic [DIV_W-1:0]  eff;
    logic [FRAC_W:0]   sum;

    always_comb begin
        eff   = (div_i < UNITY) ? UNITY : div_i;
        sum   = {1'b0, acc_i} + {1'b0, eff[FRAC_W-1:0]};
        len_o = {1'b0, eff[DIV_W-1:FRAC_W]} + LEN_W'(sum[FRAC_W]);
        acc_o = sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/fclk_edge_win.sv
module fclk_edge_win #(
    parameter int HALF_W = 10,
    parameter int EDGE_W = 9
) (
    input  logic [HALF_W-1:0] half_i,
    input  logic [EDGE_W-1:0] rise_i,
    input  logic [EDGE_W-1:0] fall_i,
    output logic              high_o
);
    localparam int CMP_W = (HALF_W > EDGE_W) ? HALF_W : EDGE_W;

    logic [CMP_W-1:0] h, r, f;

    always_comb begin
        h = CMP_W'(half_i);
        r = CMP_W'(rise_i);
        f = CMP_W'(fall_i);
        if (r <= f) high_o = (h >= r) && (h < f);
        else        high_o = (h >= r) || (h < f);
    end
endmodule

// File: rtl/fclk_divider.sv
module fclk_divider #(
    parameter int DIV_W    = fclk_pkg::DEF_DIV_W,
    parameter int FRAC_W   = fclk_pkg::DEF_FRAC_W,
    parameter int EDGE_W   = fclk_pkg::DEF_EDGE_W,
    parameter int CFG_W    = fclk_pkg::DEF_CFG_W,
    parameter int FALL_LSB = fclk_pkg::DEF_FALL_LSB,
    parameter int RISE_LSB = fclk_pkg::DEF_RISE_LSB
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_cfg_i,
    input  logic [CFG_W-1:0] edge_cfg_i,
    input  logic             invert_i,
    output logic             pix_clk_o,
    output logic             tick_o
);
    localparam int INT_W  = DIV_W - FRAC_W;
    localparam int LEN_W  = INT_W + 1;
    localparam int HALF_W = LEN_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
        logic [FRAC_W-1:0] acc;
        logic [EDGE_W-1:0] rise;
        logic [EDGE_W-1:0] fall;
        logic              hi;
        logic              lo;
        logic              tick;
    } state_t;

    state_t s_d, s_q;

    logic [LEN_W-1:0]  cnt_inc;
    logic              wrap;
    logic [LEN_W-1:0]  nxt_cnt;
    logic [EDGE_W-1:0] rise_use, fall_use;
    logic [LEN_W-1:0]  new_len;
    logic [FRAC_W-1:0] new_acc;
    logic [1:0]        win;

    assign cnt_inc  = s_q.cnt + LEN_W'(1);
    assign wrap     = (cnt_inc == s_q.len);
    assign nxt_cnt  = wrap ? '0 : cnt_inc;
    assign rise_use = wrap ? edge_cfg_i[RISE_LSB +: EDGE_W] : s_q.rise;
    assign fall_use = wrap ? edge_cfg_i[FALL_LSB +: EDGE_W] : s_q.fall;

    fclk_period_calc #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W)
    ) u_calc (
        .div_i(div_cfg_i),
        .acc_i(s_q.acc),
        .len_o(new_len),
        .acc_o(new_acc)
    );

    // slot 0 is the first half of the coming cycle, slot 1 the second half
    for (genvar g = 0; g < 2; g++) begin : g_half
        fclk_edge_win #(
            .HALF_W(HALF_W),
            .EDGE_W(EDGE_W)
        ) u_win (
            .half_i({nxt_cnt, 1'(g)}),
            .rise_i(rise_use),
            .fall_i(fall_use),
            .high_o(win[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.cnt  = nxt_cnt;
        s_d.tick = wrap;
        s_d.hi   = win[0];
        s_d.lo   = win[1];
        if (wrap) begin
            s_d.len  = new_len;
            s_d.acc  = new_acc;
            s_d.rise = rise_use;
            s_d.fall = fall_use;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.cnt  <= '0;
            s_q.len  <= LEN_W'(1);
            s_q.acc  <= '0;
            s_q.rise <= '0;
            s_q.fall <= '0;
            s_q.hi   <= 1'b0;
            s_q.lo   <= 1'b0;
            s_q.tick <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_clk_o = (clk_i ? s_q.hi : s_q.lo) ^ invert_i;
    assign tick_o    = s_q.tick;

    // R10
    tick_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (s_q.cnt == '0));

    // R10
    tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && s_q.len > LEN_W'(1)) |=> !tick_o);

    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wrap |=> ($stable(s_q.len) && $stable(s_q.rise) && $stable(s_q.fall)));

    // R4
    len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.len != '0);

    // R5
    bypass_wave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.len == LEN_W'(1) && s_q.rise == '0 && s_q.fall == EDGE_W'(1))
        |-> (s_q.hi && !s_q.lo));
endmodule

// File: tb/tb_fclk_divider.sv
`timescale 1ns/1ps
module tb_fclk_divider;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] div_cfg_i = 12'h010;
    logic [31:0] edge_cfg_i = 32'h0001_0000;
    logic        invert_i = 1'b0;
    logic        pix_clk_o;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic hs, ls, tk;
    int per_len[16];
    int per_hi[16];
    int per_first[16];

    fclk_divider dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .div_cfg_i(div_cfg_i),
        .edge_cfg_i(edge_cfg_i), .invert_i(invert_i),
        .pix_clk_o(pix_clk_o), .tick_o(tick_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic logic [31:0] mk_edge(input int rise, input int fall);
        return (32'(fall) << 16) | 32'(rise);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i); #2;
        hs = pix_clk_o; tk = tick_o;
        @(negedge clk_i); #2;
        ls = pix_clk_o;
    endtask

    task automatic measure(input int n);
        do step(); while (!tk);
        for (int p = 0; p < n; p++) begin
            per_len[p] = 0; per_hi[p] = 0; per_first[p] = int'(hs);
            do begin
                per_len[p]++;
                per_hi[p] += int'(hs) + int'(ls);
                step();
            end while (!tk);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            step();
            check(hs == 1'b0, "R1 high half in reset", int'(hs), 0);
            check(ls == 1'b0, "R1 low half in reset", int'(ls), 0);
            check(tk == 1'b0, "R1 tick in reset", int'(tk), 0);
        end
    endtask

    task automatic t_bypass();
        div_cfg_i = 12'h010; edge_cfg_i = mk_edge(0, 1); invert_i = 0;
        measure(4);
        for (int p = 0; p < 4; p++) begin
            check(per_len[p] == 1, "R5 bypass period", per_len[p], 1);
            check(per_hi[p] == 1, "R5 bypass high slots", per_hi[p], 1);
            check(per_first[p] == 1, "R5 bypass first half", per_first[p], 1);
        end
    endtask

    task automatic t_below_min();
        div_cfg_i = 12'h005; edge_cfg_i = mk_edge(0, 1);
        measure(4);
        for (int p = 0; p < 4; p++) begin
            check(per_len[p] == 1, "R4 clamped period", per_len[p], 1);
            check(per_hi[p] == 1, "R4 clamped high slots", per_hi[p], 1);
        end
    endtask

    task automatic t_int_div4();
        div_cfg_i = 12'h040; edge_cfg_i = mk_edge(0, 4);
        measure(3);
        for (int p = 0; p < 3; p++) begin
            check(per_len[p] == 4, "R2 divide 4 period", per_len[p], 4);
            check(per_hi[p] == 4, "R6 divide 4 half duty", per_hi[p], 4);
            check(per_first[p] == 1, "R6 divide 4 first half", per_first[p], 1);
        end
        edge_cfg_i = mk_edge(2, 6);
        measure(2);
        for (int p = 0; p < 2; p++) begin
            check(per_hi[p] == 4, "R6 shifted window slots", per_hi[p], 4);
            check(per_first[p] == 0, "R6 shifted window first half", per_first[p], 0);
        end
    endtask

    task automatic t_half_step();
        div_cfg_i = 12'h030; edge_cfg_i = mk_edge(0, 3);
        measure(3);
        for (int p = 0; p < 3; p++) begin
            check(per_len[p] == 3, "R2 divide 3 period", per_len[p], 3);
            check(per_hi[p] == 3, "R6 half-cycle fall", per_hi[p], 3);
        end
    endtask

    task automatic t_wrap();
        div_cfg_i = 12'h040; edge_cfg_i = mk_edge(6, 2);
        measure(3);
        for (int p = 0; p < 3; p++) begin
            check(per_hi[p] == 4, "R7 wrapped slots", per_hi[p], 4);
            check(per_first[p] == 1, "R7 wrapped first half", per_first[p], 1);
        end
    endtask

    task automatic t_invert();
        div_cfg_i = 12'h040; edge_cfg_i = mk_edge(0, 2); invert_i = 1;
        measure(3);
        for (int p = 0; p < 3; p++) begin
            check(per_hi[p] == 6, "R8 inverted slots", per_hi[p], 6);
            check(per_first[p] == 0, "R8 inverted first half", per_first[p], 0);
        end
        invert_i = 0;
    endtask

    task automatic t_frac(input logic [11:0] dv, input int ip, input int fr);
        int sum;
        div_cfg_i = dv; edge_cfg_i = mk_edge(0, 2);
        measure(16);
        sum = 0;
        for (int p = 0; p < 16; p++) begin
            sum += per_len[p];
            check(per_len[p] == ip || per_len[p] == ip + 1, "R3 period floor or ceil", per_len[p], ip);
            check(per_hi[p] == 2, "R3 high slots", per_hi[p], 2);
            if (fr == 8 && p > 0)
                check(per_len[p] != per_len[p-1], "R3 alternation", per_len[p], 5 - per_len[p-1]);
        end
        check(sum == 16 * ip + fr, "R3 sum of 16 periods", sum, 16 * ip + fr);
    endtask

    task automatic t_change();
        int len;
        div_cfg_i = 12'h040; edge_cfg_i = mk_edge(0, 4);
        measure(2);
        div_cfg_i = 12'h020;
        len = 0;
        do begin len++; step(); end while (!tk);
        check(len == 4, "R9 running period kept", len, 4);
        len = 0;
        do begin len++; step(); end while (!tk);
        check(len == 2, "R9 new ratio at boundary", len, 2);
    endtask

    task automatic t_tick_width();
        int ticks;
        div_cfg_i = 12'h050; edge_cfg_i = mk_edge(0, 5);
        measure(1);
        ticks = 0;
        for (int i = 0; i < 10; i++) begin
            if (tk) ticks++;
            step();
        end
        check(ticks == 2, "R10 ticks in 10 cycles at divide 5", ticks, 2);
    endtask

    initial begin
        t_reset();
        @(negedge clk_i); rst_ni = 1'b1;
        t_bypass();
        t_below_min();
        t_int_div4();
        t_half_step();
        t_wrap();
        t_invert();
        t_frac(12'h028, 2, 8);
        t_frac(12'h024, 2, 4);
        t_change();
        t_tick_width();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule